// File: doc/BRIEF.md
# Segmented Triple-Voted ALU

This block computes a 12-bit ALU operation (addition or one of three bitwise logic functions) on a datapath only four bits wide. Three identical 4-bit slices all work on the same operand segment at the same time. A bitwise two-of-three vote merges their outputs, so any fault confined to one slice is masked. The segments are handled one per cycle, least significant first. The voted carry of each pass is registered and used as the carry-in of the next pass.

A start pulse, sampled while the block is idle, captures both operands and the operation code. Three clock edges later the block presents the assembled 12-bit result and the carry-out, and raises a one-cycle done pulse. Each slice has test inputs that XOR a mask onto its sum and its carry. A sticky flag reports whether any slice disagreed with the vote during the last operation.

Top module: `tvalu_top`

## Requirements
- R1: With opcode 2'b00 (add), the result is (opa + opb) mod 4096 and carry_out is bit 12 of the true sum. Carries pass from the low segment to the middle segment and from the middle segment to the high segment. The first segment uses a carry-in of 0.
- R2: Opcode 2'b01 gives opa AND opb, 2'b10 gives opa OR opb, and 2'b11 gives opa XOR opb. For these three opcodes carry_out is 0.
- R3: A start is accepted when start is high at a rising edge while the block is idle. done is then high for exactly one cycle, following the third rising edge after the accepting edge. result and carry_out are valid while done is high and hold their values until the next accepted start.
- R4: A start that arrives while an operation is in progress is ignored. The running operation completes with its own operands, and the ignored start produces no second done pulse.
- R5: When a nonzero fault mask is applied to only one slice (the 4-bit sum mask, the carry mask, or both), result and carry_out are the same as with no fault. Slice k uses inj_sum bits [4k+3:4k] and inj_carry bit k.
- R6: mismatch is set when any slice's sum differs from the voted sum during the operation. For addition it is also set when any slice's carry differs from the voted carry. Once set, it stays high until the next accepted start clears it.
- R7: With all fault masks zero, mismatch is low after the operation.
- R8: While rst_n is low at a rising edge (synchronous reset), the block returns to idle, and done, result, carry_out and mismatch all become 0. An operation in progress is abandoned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request to begin an operation |
| opa | input | 12 | First operand |
| opb | input | 12 | Second operand |
| op | input | 2 | Operation code: 00 add, 01 and, 10 or, 11 xor |
| inj_sum | input | 12 | Sum fault masks, 4 bits per slice |
| inj_carry | input | 3 | Carry fault masks, 1 bit per slice |
| done | output | 1 | One-cycle completion pulse |
| result | output | 12 | Voted 12-bit result |
| carry_out | output | 1 | Voted final carry (0 for logic ops) |
| mismatch | output | 1 | Sticky slice disagreement flag |

## Verification
A segment counter that is off by one would store a voted segment in the wrong result field, or start the done pulse a cycle early or late. The bench would see this at the first done of any operation with distinct segment values. A carry register that is not cleared or not advanced would corrupt an add whose low segments carry, and that error shows in the result and carry_out of the same operation. A faulty voter or a broken mask routing would let a single-slice fault into the result, or would leave the sticky flag wrong. The bench reads both at the done cycle of the faulted operation.

// File: rtl/tvalu_pkg.sv
// Shared types and constants for the segmented triple-voted ALU.
// Assumes: exactly three redundant lanes; opcode values are fixed by the port contract.
package tvalu_pkg;
    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_AND = 2'b01,
        OP_OR  = 2'b10,
        OP_XOR = 2'b11
    } alu_op_e;

    localparam int LANES = 3;
endpackage

// File: rtl/tvalu_slice.sv
// One narrow ALU lane: add with carry-in, or a bitwise function, on W-bit segments.
// Its sum and carry pass through XOR fault masks used for test.
// Assumes: the carry output is forced to 0 for logic opcodes before the mask is applied.
module tvalu_slice
    import tvalu_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  alu_op_e      op,
    input  logic [W-1:0] flip_sum,
    input  logic         flip_cy,
    output logic [W-1:0] y,
    output logic         co
);
    logic [W:0] wide;

    // Purpose: the fault-free lane result.
    always_comb begin
        wide = '0;
        case (op)
            OP_ADD:  wide = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
            OP_AND:  wide = {1'b0, a & b};
            OP_OR:   wide = {1'b0, a | b};
            default: wide = {1'b0, a ^ b};
        endcase
    end

    // Purpose: apply the test fault masks.
    always_comb begin
        y  = wide[W-1:0] ^ flip_sum;
        co = wide[W] ^ flip_cy;
    end
endmodule

// File: rtl/tvalu_vote.sv
// Bitwise two-of-three majority voter with a disagreement indicator.
// Assumes: at most one input is wrong, so the vote equals the fault-free value.
module tvalu_vote #(
    parameter int W = 4
) (
    input  logic [W-1:0] x0,
    input  logic [W-1:0] x1,
    input  logic [W-1:0] x2,
    output logic [W-1:0] v,
    output logic         dis
);
    // Purpose: majority of each bit position, and a flag when any input differs from it.
    always_comb begin
        v   = (x0 & x1) | (x0 & x2) | (x1 & x2);
        dis = |((x0 ^ v) | (x1 ^ v) | (x2 ^ v));
    end
endmodule

// File: rtl/tvalu_ctrl.sv
// Pass sequencer: accepts a start when idle, steps through NUM_SEG passes, then
// pulses done for one cycle.
// Assumes: NUM_SEG >= 1; a start seen while busy is dropped.
module tvalu_ctrl #(
    parameter int NUM_SEG = 3,
    localparam int IDX_W  = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             accept,
    output logic             busy,
    output logic [IDX_W-1:0] idx,
    output logic             last,
    output logic             done
);
    // Purpose: decode which start is taken and which pass is the final one.
    always_comb begin
        accept = start && !busy;
        last   = (idx == IDX_W'(NUM_SEG - 1));
    end

    // Purpose: busy state, pass index and the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            idx  <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                busy <= 1'b1;
                idx  <= '0;
            end else if (busy) begin
                if (last) begin
                    busy <= 1'b0;
                    idx  <= '0;
                    done <= 1'b1;
                end else begin
                    idx <= idx + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/tvalu_top.sv
// Segmented triple-voted ALU: three identical SEG_W-bit lanes compute each segment
// in parallel. Their outputs are voted, and the voted segments are assembled over
// NUM_SEG passes.
// Assumes: fault masks are held steady for the whole operation; the result is only
// meaningful while done is high or afterwards.
module tvalu_top
    import tvalu_pkg::*;
#(
    parameter int SEG_W   = 4,
    parameter int NUM_SEG = 3,
    localparam int DW     = SEG_W * NUM_SEG,
    localparam int IDX_W  = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [DW-1:0]          opa,
    input  logic [DW-1:0]          opb,
    input  logic [1:0]             op,
    input  logic [LANES*SEG_W-1:0] inj_sum,
    input  logic [LANES-1:0]       inj_carry,
    output logic                   done,
    output logic [DW-1:0]          result,
    output logic                   carry_out,
    output logic                   mismatch
);
    logic             accept, busy, last;
    logic [IDX_W-1:0] idx;
    logic [DW-1:0]    a_q, b_q, res_q;
    alu_op_e          op_q;
    logic             carry_q, flag_q;
    logic [SEG_W-1:0] seg_a, seg_b, v_sum;
    logic [SEG_W-1:0] l_sum [LANES];
    logic             l_cy  [LANES];
    logic [0:0]       v_cy;
    logic             dis_sum, dis_cy;

    tvalu_ctrl #(.NUM_SEG(NUM_SEG)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .accept(accept),
        .busy(busy), .idx(idx), .last(last), .done(done)
    );

    // Purpose: select the operand segment for the current pass.
    always_comb begin
        seg_a = a_q[idx*SEG_W +: SEG_W];
        seg_b = b_q[idx*SEG_W +: SEG_W];
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        tvalu_slice #(.W(SEG_W)) u_slice (
            .a(seg_a), .b(seg_b), .cin(carry_q), .op(op_q),
            .flip_sum(inj_sum[g*SEG_W +: SEG_W]), .flip_cy(inj_carry[g]),
            .y(l_sum[g]), .co(l_cy[g])
        );
    end

    tvalu_vote #(.W(SEG_W)) u_vote_sum (
        .x0(l_sum[0]), .x1(l_sum[1]), .x2(l_sum[2]), .v(v_sum), .dis(dis_sum)
    );

    tvalu_vote #(.W(1)) u_vote_cy (
        .x0(l_cy[0]), .x1(l_cy[1]), .x2(l_cy[2]), .v(v_cy), .dis(dis_cy)
    );

    // Purpose: capture the operands and the opcode on an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q  <= '0;
            b_q  <= '0;
            op_q <= OP_ADD;
        end else if (accept) begin
            a_q  <= opa;
            b_q  <= opb;
            op_q <= alu_op_e'(op);
        end
    end

    // Purpose: carry chain, result assembly and the sticky disagreement flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            carry_q <= 1'b0;
            res_q   <= '0;
            flag_q  <= 1'b0;
        end else if (accept) begin
            carry_q <= 1'b0;
            flag_q  <= 1'b0;
        end else if (busy) begin
            carry_q <= v_cy[0];
            res_q[idx*SEG_W +: SEG_W] <= v_sum;
            if (dis_sum || (op_q == OP_ADD && dis_cy))
                flag_q <= 1'b1;
        end
    end

    // Purpose: drive the outputs from the registered state.
    always_comb begin
        result    = res_q;
        carry_out = carry_q;
        mismatch  = flag_q;
    end
endmodule

// File: rtl/tvalu_chk.sv
// Protocol checker for tvalu_top, attached with bind.
// Assumes: NUM_SEG is small enough for the cycle counter width.
module tvalu_chk
    import tvalu_pkg::*;
#(
    parameter int NUM_SEG = 3,
    parameter int DW      = 12,
    localparam int CW     = $clog2(NUM_SEG + 1) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input alu_op_e       op_q,
    input logic [DW-1:0] a_q,
    input logic [DW-1:0] result,
    input logic          carry_out,
    input logic          mismatch
);
    logic [CW-1:0] since;

    // Purpose: count the edges since the last accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n)
            since <= '0;
        else if (start && !busy)
            since <= CW'(1);
        else if (since == CW'(NUM_SEG))
            since <= '0;
        else if (since != '0)
            since <= since + 1'b1;
    end

    AST_DONE_DUE: assert property (@(posedge clk) disable iff (!rst_n)
        (since == CW'(NUM_SEG)) |=> done);  // R3
    AST_DONE_ONLY_WHEN_DUE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(since == CW'(NUM_SEG)));  // R3
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);  // R3
    AST_BUSY_HOLDS_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(a_q));  // R4
    AST_LOGIC_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_q != OP_ADD) |-> !carry_out);  // R2
    AST_FLAG_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> !mismatch);  // R6
    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> (!done && !mismatch && !carry_out && result == '0));  // R8
endmodule

bind tvalu_top tvalu_chk #(.NUM_SEG(NUM_SEG), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .op_q(op_q), .a_q(a_q), .result(result), .carry_out(carry_out),
    .mismatch(mismatch)
);

// File: tb/tvalu_top_test.sv
module tvalu_top_test;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [11:0] opa = '0, opb = '0;
    logic [1:0]  op = '0;
    logic [11:0] inj_sum = '0;
    logic [2:0]  inj_carry = '0;
    logic        done, carry_out, mismatch;
    logic [11:0] result;
    int total = 0, bad = 0;

    always #(PERIOD/2) clk = ~clk;

    tvalu_top uut (
        .clk(clk), .rst_n(rst_n), .start(start), .opa(opa), .opb(opb), .op(op),
        .inj_sum(inj_sum), .inj_carry(inj_carry), .done(done), .result(result),
        .carry_out(carry_out), .mismatch(mismatch)
    );

    function automatic logic [12:0] model(input logic [11:0] a, input logic [11:0] b,
                                          input logic [1:0] o);
        case (o)
            2'b00:   model = {1'b0, a} + {1'b0, b};
            2'b01:   model = {1'b0, a & b};
            2'b10:   model = {1'b0, a | b};
            default: model = {1'b0, a ^ b};
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Runs one operation; tag names the requirement under test.
    task automatic run_op(input logic [11:0] a, input logic [11:0] b, input logic [1:0] o,
                          input logic [11:0] fs, input logic [2:0] fc, input string tag);
        logic [12:0] e;
        bit ef;
        e  = model(a, b, o);
        ef = (fs != 0) || (o == 2'b00 && fc != 0);
        @(negedge clk);
        opa = a; opb = b; op = o; inj_sum = fs; inj_carry = fc; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 1; i <= 3; i++) begin
            if (i > 1) @(negedge clk);
            if (i < 3) check(done == 1'b0, {tag, " R3 early done"}, 32'(done), 0);
        end
        @(negedge clk);
        check(done == 1'b1, {tag, " R3 done"}, 32'(done), 1);
        check(result == e[11:0], {tag, " result"}, 32'(result), 32'(e[11:0]));
        check(carry_out == e[12], {tag, " carry"}, 32'(carry_out), 32'(e[12]));
        check(mismatch == ef, ef ? {tag, " R6 flag"} : {tag, " R7 flag"},
              32'(mismatch), 32'(ef));
        @(negedge clk);
        check(done == 1'b0, {tag, " R3 pulse width"}, 32'(done), 0);
        check(result == e[11:0], {tag, " R3 hold"}, 32'(result), 32'(e[11:0]));
    endtask

    initial begin
        #(PERIOD * 150000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R8: reset state
        check(done == 0 && result == 0 && carry_out == 0 && mismatch == 0,
              "R8 reset state", {result, 3'b0, done, carry_out, mismatch}, 0);
        rst_n = 1'b1;

        // R1: directed adds, including carries across segment boundaries
        run_op(12'hFFF, 12'h001, 2'b00, 0, 0, "R1 full ripple");
        run_op(12'h00F, 12'h001, 2'b00, 0, 0, "R1 low to mid");
        run_op(12'h0F0, 12'h010, 2'b00, 0, 0, "R1 mid to high");
        run_op(12'h800, 12'h800, 2'b00, 0, 0, "R1 top carry");
        run_op(12'h123, 12'h456, 2'b00, 0, 0, "R1 no carry");
        // R2: logic ops, carry forced to 0
        run_op(12'hF0F, 12'hFF0, 2'b01, 0, 0, "R2 and");
        run_op(12'hA50, 12'h05A, 2'b10, 0, 0, "R2 or");
        run_op(12'hFFF, 12'hFFF, 2'b11, 0, 0, "R2 xor");
        // R5: single-slice faults in each lane
        run_op(12'hFFF, 12'h001, 2'b00, 12'h00F, 3'b001, "R5 lane0");
        run_op(12'hFFF, 12'h001, 2'b00, 12'h0A0, 3'b010, "R5 lane1");
        run_op(12'h7FF, 12'h801, 2'b00, 12'hF00, 3'b100, "R5 lane2");
        run_op(12'h3C3, 12'h0FF, 2'b11, 12'h000, 3'b010, "R5 logic carry mask");
        run_op(12'h3C3, 12'h0FF, 2'b11, 12'h500, 3'b000, "R5 logic sum mask");
        // R6: the flag clears at the next accepted start
        run_op(12'h111, 12'h222, 2'b00, 0, 0, "R6 clear after fault");

        // R4: a start while busy is ignored
        @(negedge clk);
        opa = 12'h0AB; opb = 12'h011; op = 2'b00; inj_sum = 0; inj_carry = 0; start = 1'b1;
        @(negedge clk);
        opa = 12'hFFF; opb = 12'hFFF; op = 2'b11;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(done == 1'b1, "R4 first done", 32'(done), 1);
        check(result == 12'h0BC, "R4 operands kept", 32'(result), 32'h0BC);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check(done == 1'b0, "R4 no second done", 32'(done), 0);
        end

        // R8: reset in the middle of an operation
        @(negedge clk);
        opa = 12'hFFF; opb = 12'h001; op = 2'b00; inj_sum = 12'h00F; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(done == 0 && result == 0 && carry_out == 0 && mismatch == 0,
              "R8 mid-op reset", {result, 3'b0, done, carry_out, mismatch}, 0);
        rst_n = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check(done == 1'b0, "R8 abandoned op", 32'(done), 0);
        end

        // Random operations with at most one faulty lane (R1 R2 R5 R6 R7)
        for (int n = 0; n < 300; n++) begin
            logic [11:0] fs;
            logic [2:0]  fc;
            int lane;
            fs = 0; fc = 0;
            lane = $urandom % 4;
            if (lane < 3) begin
                fs[lane*4 +: 4] = 4'($urandom);
                fc[lane] = 1'($urandom);
            end
            run_op(12'($urandom), 12'($urandom), 2'($urandom), fs, fc, "R5 random");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule